// File: doc/BRIEF.md
# I2C Controller Control and Status Register

This block is the processor-facing 8-bit control register of a multi-address I2C controller. It stores the bus-error flag and its interrupt enable, the two acknowledge-enable controls handed to the byte shifter, and the master or slave mode of the controller. Software writes to the register are turned into single-cycle start, repeated-start and stop requests for the bus engine.

The bus engine reports back through level and pulse inputs: an illegal start or stop seen on the wires, whether a data transfer is under way, arbitration lost, transfer complete, and the per-byte transfer-interrupt flag. A bus error during a transfer latches the error flag, pulses a clear of the controller's operation enable, holds the controller and drops it to slave mode without a stop.

Mode tracking is a three-state machine. States: SLAVE (idle or addressed as slave), MASTER (owns the bus), STOPPING (stop requested, still master until the current transfer completes). Transitions: T_START (SLAVE to MASTER, write with bit 4 = 1), T_RSTART (MASTER to MASTER, write with bits 4 and 5 = 1), T_STOP_NOW (MASTER to SLAVE, write with bit 4 = 0 while the transfer-interrupt flag is 1), T_STOP_DEFER (MASTER to STOPPING, same write while the flag is 0), T_DONE (STOPPING to SLAVE on transfer complete), T_ARB (MASTER or STOPPING to SLAVE on arbitration lost), T_ERR (any state to SLAVE on a bus error). Priority is T_ERR, then T_ARB, then T_DONE, then register writes.

Top module: `i2c_ctrl_reg`

## Requirements
- R1: After reset every register bit is 0: the read value is 0x00 and all outputs are low.
- R2: When the illegal-condition input and the transfer-busy input are both 1 at a clock edge, bit 7 (error flag) and `halt` read 1 from the next cycle; the illegal-condition input alone, with busy 0, has no effect.
- R3: A write with bit 7 = 0 clears the error flag; a write with bit 7 = 1 leaves it as it was; if a write with bit 7 = 0 meets a new error in the same cycle, the flag stays 1.
- R4: A read with the read-modify-write indication high returns bit 7 as 1 whatever the flag holds.
- R5: When the error flag goes from 0 to 1, `enable_clr` is high for exactly that one cycle, `halt` stays high while the flag is set, and master mode is left without any stop request.
- R6: `err_irq` is 1 exactly when bit 6 (interrupt enable) and the error flag are both 1.
- R7: In slave mode a write with bit 4 = 1 gives a one-cycle `start_req` pulse in the cycle after the write and enters master mode; bit 4 then reads 1.
- R8: In master mode a write with bits 4 and 5 both 1 gives a one-cycle `rstart_req`; bit 5 always reads 0; bit 5 written in slave mode has no effect.
- R9: In master mode a write with bit 4 = 0 gives a one-cycle `stop_req`; with the transfer-interrupt input at 1 the block is in slave mode in the next cycle, with it at 0 `master_mode` stays 1 (bit 4 reads 0) until transfer complete is seen.
- R10: A write with bit 4 = 0 and bit 5 = 1 in master mode issues only the stop request; at most one of the three requests is high in any cycle.
- R11: Arbitration lost in master or stopping mode returns the block to slave mode in the next cycle with no request pulse.
- R12: Bits 3 and 2 are stored from writes and drive `ack_en` and `gcall_ack_en` respectively.
- R13: Bits 1 and 0 read 0 and ignore writes; the read data is 0x00 whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rmw | input | 1 | Read belongs to a read-modify-write access |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_bad_cond | input | 1 | Illegal start or stop seen on the bus |
| bus_busy | input | 1 | Data transfer in progress |
| bus_arb_lost | input | 1 | Arbitration lost |
| bus_xfer_done | input | 1 | Current transfer completed |
| bus_xfer_int | input | 1 | Transfer-interrupt flag of the bus engine |
| start_req | output | 1 | One-cycle start condition request |
| rstart_req | output | 1 | One-cycle repeated-start request |
| stop_req | output | 1 | One-cycle stop condition request |
| master_mode | output | 1 | Controller acts as master (MASTER or STOPPING) |
| halt | output | 1 | Hold mode, transfer aborted by bus error |
| enable_clr | output | 1 | One-cycle clear of the operation enable |
| err_irq | output | 1 | Bus-error interrupt request |
| ack_en | output | 1 | Acknowledge on the 9th clock of received bytes |
| gcall_ack_en | output | 1 | Acknowledge a general-call address in slave mode |

## Verification
A wrong mode state shows within one cycle of the next write: a missing or extra request pulse and a wrong bit 4 on read, or a `master_mode` that fails to fall after arbitration loss or transfer completion. A wrong error flag shows at once on `halt` and `err_irq` and on bit 7 of a plain read, while a read-modify-write read must hide it. Each step of the bench is compared one cycle after it is driven, so any divergence is caught in the cycle it first reaches the ports.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;

    localparam int REG_W     = 8;
    localparam int BIT_ERR   = 7;
    localparam int BIT_IE    = 6;
    localparam int BIT_RST   = 5;
    localparam int BIT_MST   = 4;
    localparam int BIT_ACK   = 3;
    localparam int BIT_GCA   = 2;
    localparam int CFG_N     = 3;

    typedef enum logic [1:0] {
        ST_SLAVE    = 2'd0,
        ST_MASTER   = 2'd1,
        ST_STOPPING = 2'd2
    } mode_t;

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
    } req_t;

endpackage

// File: rtl/i2c_ctrl_errflag.sv
module i2c_ctrl_errflag (
    input  logic clk,
    input  logic rst_n,
    input  logic bad_cond,
    input  logic busy,
    input  logic wr_en,
    input  logic wr_bit,
    output logic err_hit,
    output logic err,
    output logic enable_clr
);

    assign err_hit = bad_cond & busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err        <= 1'b0;
            enable_clr <= 1'b0;
        end else begin
            enable_clr <= err_hit & ~err;
            if (err_hit) begin
                err <= 1'b1;
            end else if (wr_en && !wr_bit) begin
                err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/i2c_ctrl_cfgbits.sv
module i2c_ctrl_cfgbits #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] din,
    output logic [N-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= 1'b0;
            end else if (load) begin
                q[g] <= din[g];
            end
        end
    end

endmodule

// File: rtl/i2c_ctrl_mode_fsm.sv
module i2c_ctrl_mode_fsm
    import i2c_ctrl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  logic  wr_master,
    input  logic  wr_rstart,
    input  logic  xfer_int,
    input  logic  xfer_done,
    input  logic  arb_lost,
    input  logic  err_hit,
    output mode_t state,
    output req_t  req
);

    mode_t nxt;
    req_t  req_nxt;

    always_comb begin
        nxt     = state;
        req_nxt = '0;
        if (err_hit) begin
            nxt = ST_SLAVE;                         // T_ERR
        end else if (arb_lost && state != ST_SLAVE) begin
            nxt = ST_SLAVE;                         // T_ARB
        end else if (xfer_done && state == ST_STOPPING) begin
            nxt = ST_SLAVE;                         // T_DONE
        end else if (wr_en) begin
            unique case (state)
                ST_SLAVE: begin
                    if (wr_master) begin
                        nxt           = ST_MASTER;  // T_START
                        req_nxt.start = 1'b1;
                    end
                end
                ST_MASTER: begin
                    if (!wr_master) begin
                        req_nxt.stop = 1'b1;
                        nxt = xfer_int ? ST_SLAVE : ST_STOPPING; // T_STOP_NOW / T_STOP_DEFER
                    end else if (wr_rstart) begin
                        req_nxt.rstart = 1'b1;      // T_RSTART
                    end
                end
                ST_STOPPING: begin
                    nxt = ST_STOPPING;
                end
                default: begin
                    nxt = ST_SLAVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SLAVE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req <= '0;
        end else begin
            req <= req_nxt;
        end
    end

endmodule

// File: rtl/i2c_ctrl_readmux.sv
module i2c_ctrl_readmux
    import i2c_ctrl_pkg::*;
(
    input  logic             rd_en,
    input  logic             rmw,
    input  logic             err,
    input  logic             ie,
    input  logic             mst,
    input  logic             ack,
    input  logic             gca,
    output logic [REG_W-1:0] rdata
);

    logic [REG_W-1:0] view;

    always_comb begin
        view          = '0;
        view[BIT_ERR] = err | rmw;
        view[BIT_IE]  = ie;
        view[BIT_MST] = mst;
        view[BIT_ACK] = ack;
        view[BIT_GCA] = gca;
        rdata         = rd_en ? view : '0;
    end

endmodule

// File: rtl/i2c_ctrl_reg.sv
module i2c_ctrl_reg
    import i2c_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             reg_rd,
    input  logic             reg_rmw,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             bus_bad_cond,
    input  logic             bus_busy,
    input  logic             bus_arb_lost,
    input  logic             bus_xfer_done,
    input  logic             bus_xfer_int,
    output logic             start_req,
    output logic             rstart_req,
    output logic             stop_req,
    output logic             master_mode,
    output logic             halt,
    output logic             enable_clr,
    output logic             err_irq,
    output logic             ack_en,
    output logic             gcall_ack_en
);

    logic             err_hit;
    logic             err;
    logic [CFG_N-1:0] cfg_q;
    logic [CFG_N-1:0] cfg_d;
    mode_t            state;
    req_t             req;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[1:0];
    assign cfg_d = {reg_wdata[BIT_IE], reg_wdata[BIT_ACK], reg_wdata[BIT_GCA]};

    i2c_ctrl_errflag u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .bad_cond   (bus_bad_cond),
        .busy       (bus_busy),
        .wr_en      (reg_wr),
        .wr_bit     (reg_wdata[BIT_ERR]),
        .err_hit    (err_hit),
        .err        (err),
        .enable_clr (enable_clr)
    );

    i2c_ctrl_cfgbits #(.N(CFG_N)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (reg_wr),
        .din   (cfg_d),
        .q     (cfg_q)
    );

    i2c_ctrl_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_master (reg_wdata[BIT_MST]),
        .wr_rstart (reg_wdata[BIT_RST]),
        .xfer_int  (bus_xfer_int),
        .xfer_done (bus_xfer_done),
        .arb_lost  (bus_arb_lost),
        .err_hit   (err_hit),
        .state     (state),
        .req       (req)
    );

    i2c_ctrl_readmux u_rd (
        .rd_en (reg_rd),
        .rmw   (reg_rmw),
        .err   (err),
        .ie    (cfg_q[2]),
        .mst   (state == ST_MASTER),
        .ack   (cfg_q[1]),
        .gca   (cfg_q[0]),
        .rdata (reg_rdata)
    );

    assign start_req    = req.start;
    assign rstart_req   = req.rstart;
    assign stop_req     = req.stop;
    assign master_mode  = (state != ST_SLAVE);
    assign halt         = err;
    assign err_irq      = err & cfg_q[2];
    assign ack_en       = cfg_q[1];
    assign gcall_ack_en = cfg_q[0];

endmodule

// File: rtl/i2c_ctrl_reg_chk.sv
module i2c_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       bus_bad_cond,
    input logic       bus_busy,
    input logic       bus_arb_lost,
    input logic       start_req,
    input logic       rstart_req,
    input logic       stop_req,
    input logic       master_mode,
    input logic       halt,
    input logic       enable_clr,
    input logic       err_irq
);

    assert_err_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_bad_cond && bus_busy) |=> halt);

    assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[7] && !(bus_bad_cond && bus_busy)) |=> !halt);

    assert_clr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> enable_clr);

    assert_clr_only_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enable_clr |=> !enable_clr);

    assert_irq_needs_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> halt);

    assert_start_master_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> master_mode);

    assert_rstart_was_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rstart_req |-> $past(master_mode));

    assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req, rstart_req, stop_req}));

    assert_arb_to_slave_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && bus_arb_lost) |=> (!master_mode && !stop_req));

    assert_reserved_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1:0] == 2'b00);

endmodule

bind i2c_ctrl_reg i2c_ctrl_reg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .bus_bad_cond (bus_bad_cond),
    .bus_busy     (bus_busy),
    .bus_arb_lost (bus_arb_lost),
    .start_req    (start_req),
    .rstart_req   (rstart_req),
    .stop_req     (stop_req),
    .master_mode  (master_mode),
    .halt         (halt),
    .enable_clr   (enable_clr),
    .err_irq      (err_irq)
);

// File: tb/test_i2c_ctrl_reg.sv
module test_i2c_ctrl_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic       reg_rmw = 1'b0;
    logic [7:0] reg_rdata;
    logic       bus_bad_cond = 1'b0;
    logic       bus_busy = 1'b0;
    logic       bus_arb_lost = 1'b0;
    logic       bus_xfer_done = 1'b0;
    logic       bus_xfer_int = 1'b0;
    logic       start_req, rstart_req, stop_req, master_mode;
    logic       halt, enable_clr, err_irq, ack_en, gcall_ack_en;

    always #4 clk = ~clk;

    i2c_ctrl_reg i_i2c_ctrl_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rd       (reg_rd),
        .reg_rmw      (reg_rmw),
        .reg_rdata    (reg_rdata),
        .bus_bad_cond (bus_bad_cond),
        .bus_busy     (bus_busy),
        .bus_arb_lost (bus_arb_lost),
        .bus_xfer_done(bus_xfer_done),
        .bus_xfer_int (bus_xfer_int),
        .start_req    (start_req),
        .rstart_req   (rstart_req),
        .stop_req     (stop_req),
        .master_mode  (master_mode),
        .halt         (halt),
        .enable_clr   (enable_clr),
        .err_irq      (err_irq),
        .ack_en       (ack_en),
        .gcall_ack_en (gcall_ack_en)
    );

    // {start, rstart, stop, master, halt, enclr, irq, ack, gca, rdata[7:0]}
    typedef struct {
        logic [16:0] vec;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;

    // reference state kept from the requirements
    logic m_err = 0, m_ie = 0, m_ack = 0, m_gca = 0;
    int   m_st = 0; // 0 slave, 1 master, 2 stopping

    task automatic step(input logic wr, input logic [7:0] d, input logic rd,
                        input logic rmw, input logic bad, input logic busy,
                        input logic arb, input logic done, input logic xint,
                        input string tag);
        logic s, r, p, ec, hit;
        logic [7:0] rv;
        exp_t e;
        @(negedge clk);
        s = 0; r = 0; p = 0; ec = 0;
        hit = bad & busy;
        if (hit) begin
            ec = !m_err;
            m_err = 1;
        end else if (wr && !d[7]) begin
            m_err = 0;
        end
        if (wr) begin
            m_ie = d[6]; m_ack = d[3]; m_gca = d[2];
        end
        if (hit) m_st = 0;
        else if (arb && m_st != 0) m_st = 0;
        else if (done && m_st == 2) m_st = 0;
        else if (wr) begin
            if (m_st == 0) begin
                if (d[4]) begin m_st = 1; s = 1; end
            end else if (m_st == 1) begin
                if (!d[4]) begin p = 1; m_st = xint ? 0 : 2; end
                else if (d[5]) r = 1;
            end
        end
        rv = '0;
        if (rd) rv = {(m_err | rmw), m_ie, 1'b0, (m_st == 1), m_ack, m_gca, 2'b00};
        reg_wr = wr; reg_wdata = d; reg_rd = rd; reg_rmw = rmw;
        bus_bad_cond = bad; bus_busy = busy; bus_arb_lost = arb;
        bus_xfer_done = done; bus_xfer_int = xint;
        e.vec = {s, r, p, (m_st != 0), m_err, ec, (m_err & m_ie), m_ack, m_gca, rv};
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr_reg(input logic [7:0] d, input logic xint, input string tag);
        step(1, d, 0, 0, 0, 0, 0, 0, xint, tag);
    endtask

    task automatic rd_reg(input logic rmw, input string tag);
        step(0, 8'h00, 1, rmw, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic ev(input logic bad, input logic busy, input logic arb,
                      input logic done, input string tag);
        step(0, 8'h00, 0, 0, bad, busy, arb, done, 0, tag);
    endtask

    // monitor: compare one cycle after each driven step
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            logic [16:0] act;
            e = sb.pop_front();
            act = {start_req, rstart_req, stop_req, master_mode, halt, enable_clr,
                   err_irq, ack_en, gcall_ack_en, reg_rdata};
            n_checks++;
            if (act !== e.vec) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", e.tag, act, e.vec);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd_reg(0, "R1 reset value");
        wr_reg(8'h40, 0, "R6 enable irq");
        rd_reg(0, "R6 readback");
        ev(1, 0, 0, 0, "R2 illegal cond without transfer");
        ev(1, 1, 0, 0, "R2 illegal cond during transfer");
        ev(0, 0, 0, 0, "R5 enable_clr single cycle");
        rd_reg(1, "R4 rmw read");
        rd_reg(0, "R2 flag readback");
        wr_reg(8'hC0, 0, "R3 write one keeps flag");
        wr_reg(8'h40, 0, "R3 write zero clears flag");
        rd_reg(1, "R4 rmw read flag clear");
        wr_reg(8'h4F, 0, "R12 ack enables");
        rd_reg(0, "R13 reserved bits");
        wr_reg(8'h1C, 0, "R7 start from slave");
        ev(0, 0, 0, 0, "R7 start pulse ends");
        rd_reg(0, "R7 master readback");
        wr_reg(8'h3C, 0, "R8 repeated start");
        rd_reg(0, "R8 bit5 reads zero");
        wr_reg(8'h2C, 1, "R10 stop over repeated start");
        wr_reg(8'h1C, 0, "R7 start again");
        wr_reg(8'h0C, 0, "R9 deferred stop");
        rd_reg(0, "R9 stopping readback");
        ev(0, 0, 0, 0, "R9 wait for done");
        ev(0, 0, 0, 1, "R9 done to slave");
        wr_reg(8'h1C, 0, "R7 start for arb");
        ev(0, 0, 1, 0, "R11 arbitration lost");
        wr_reg(8'h20, 0, "R8 rstart ignored in slave");
        wr_reg(8'h50, 0, "R7 start for error");
        ev(1, 1, 0, 0, "R5 error drops master");
        step(1, 8'h40, 0, 0, 1, 1, 0, 0, 0, "R3 set beats clear");
        wr_reg(8'h00, 0, "R3 clear with irq off");
        wr_reg(8'h40, 0, "R6 irq enable no flag");
        step(0, 8'h00, 0, 1, 0, 0, 0, 0, 0, "R13 no read strobe");
        ev(0, 0, 0, 0, "R13 idle");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule